// File: doc/BRIEF.md
# Dual-Modulus Programmable Clock Divider

This block divides its input clock by an integer N = M·P + A without a single wide modulo counter. A small prescaler counts input clocks and divides either by P or by P+1. Two slower counters run on the prescaler's terminal ticks. The swallow counter holds the prescaler in its P+1 mode for the first A ticks of each output cycle. The main counter closes the output cycle after M ticks. The cycle therefore lasts A·(P+1) + (M−A)·P input clocks. The prescaler size P is fixed by a parameter. M and A are loaded at run time.

A load strobe offers a new M/A pair. A legal pair waits in a pending slot and takes effect at the next output-cycle boundary, so no output cycle ever mixes two settings. An illegal pair raises an error flag and leaves the running settings untouched. The block produces a one-clock pulse at each cycle boundary. It also produces a registered divided clock that is high for roughly the first half of the cycle. Everything runs on the single input clock.

Top module: `dmod_divider`

## Requirements
- R1: The spacing between consecutive `div_pulse` assertions equals A·(P+1) + (M−A)·P = M·P + A input clocks, for the active M and A.
- R2: After reset is released, the first `div_pulse` appears M·P + A clocks later, using the reset settings `DEF_M` and `DEF_A`.
- R3: The prescaler divides by P+1 during the first A prescaler periods of each output cycle and by P for the remaining periods. Its mode changes only when its own count has wrapped to zero.
- R4: When A = 0, the prescaler divides by P for the whole output cycle.
- R5: A legal load changes nothing in the output cycle that is running. The new ratio applies from the next boundary. The interval that ends at the first pulse after a load still uses the old settings.
- R6: A load is illegal when M = 0, when A ≥ P, or when M < A. An illegal load sets `cfg_err` one clock later, and the running and pending settings stay as they were.
- R7: A legal load clears `cfg_err` one clock later.
- R8: `div_pulse` is high for exactly one clock per output cycle.
- R9: `div_clk` rises only in the clock where `div_pulse` is high. Whenever the M of the cycle that just ended is 2 or more, `div_clk` does rise there. When M = 1, `div_clk` stays high.
- R10: During and directly after reset, `div_pulse` = 0, `cfg_err` = 0 and `div_clk` = 1.
- R11: Every ratio from P·(P−1) up to the largest value the port widths allow can be reached, using M = ⌊N/P⌋ and A = N mod P.
- R12: Several legal loads within one output cycle leave only the last one pending. That last one takes effect at the boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided; the only clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | One-clock strobe offering `m_in`/`a_in` |
| m_in | input | M_W | Requested main count M |
| a_in | input | A_W | Requested swallow count A |
| div_pulse | output | 1 | One-clock pulse at each output-cycle boundary |
| div_clk | output | 1 | Registered divided clock, high in the first part of each cycle |
| cfg_err | output | 1 | Set by an illegal load, cleared by a legal one |

## Verification
The hard case is the moment a new setting takes over. It has to land exactly on a cycle boundary and must never split a cycle. The bench times each load one clock after an observed pulse. It then checks the two following intervals: the first must still show the old ratio and the second the new one. The bench sweeps every contiguous ratio, then the small-M corners below P·(P−1), and repeats the same boundary timing for illegal loads and for two loads inside one cycle. Expected intervals are built as A·(P+1) + (M−A)·P from the bench's own decomposition of N.

// File: rtl/dmod_pkg.sv
package dmod_pkg;

  // Input clocks in one output cycle for main count m, swallow count a, prescaler p
  function automatic int unsigned cycle_len(int unsigned m, int unsigned a, int unsigned p);
    return (m * p) + a;
  endfunction

  // A setting is usable when the main count is non-zero, the swallow count
  // fits inside one prescaler period, and the swallow count does not exceed M
  function automatic bit setting_legal(int unsigned m, int unsigned a, int unsigned p);
    return (m != 0) && (a < p) && (m >= a);
  endfunction

  // First value of the main counter that belongs to the low phase of div_clk
  function automatic int unsigned high_span(int unsigned m);
    return (m + 1) / 2;
  endfunction

endpackage

// File: rtl/dmod_prescaler.sv
module dmod_prescaler #(
  parameter int PRE_P = 4,
  localparam int PC_W = $clog2(PRE_P + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            use_long,
  output logic            tick,
  output logic [PC_W-1:0] phase
);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] last_w;

  assign last_w = use_long ? PC_W'(PRE_P) : PC_W'(PRE_P - 1);
  assign tick   = (pc_q == last_w);
  assign phase  = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else if (tick) pc_q <= '0;
    else pc_q <= pc_q + 1'b1;
  end

  // R3: the count never passes the long modulus
  assert_pc_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pc_q) <= PRE_P);

  // R3: reaching count P is only possible in the P+1 mode
  assert_top_count_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pc_q) == PRE_P) |-> use_long);

  // R3: the mode only switches at a prescaler boundary
  assert_mode_change_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (use_long != $past(use_long)) |-> (pc_q == '0));

endmodule

// File: rtl/dmod_counters.sv
module dmod_counters #(
  parameter int M_W = 4,
  parameter int A_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [M_W-1:0] m_act,
  input  logic [A_W-1:0] a_act,
  output logic           use_long,
  output logic           cycle_end,
  output logic [M_W-1:0] m_cnt_next
);

  logic [M_W-1:0] m_cnt_q;
  logic [A_W-1:0] a_cnt_q;
  logic [A_W-1:0] a_cnt_next;
  logic           m_last;

  assign use_long  = (a_cnt_q < a_act);
  assign m_last    = (m_cnt_q == M_W'(m_act - 1'b1));
  assign cycle_end = tick && m_last;

  always_comb begin
    m_cnt_next = m_cnt_q;
    a_cnt_next = a_cnt_q;
    if (cycle_end) begin
      m_cnt_next = '0;
      a_cnt_next = '0;
    end else if (tick) begin
      m_cnt_next = m_cnt_q + 1'b1;
      if (use_long) a_cnt_next = a_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_cnt_q <= '0;
      a_cnt_q <= '0;
    end else begin
      m_cnt_q <= m_cnt_next;
      a_cnt_q <= a_cnt_next;
    end
  end

  // R1: the main counter stays below the active M
  assert_main_below_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    m_cnt_q < m_act);

  // R3: the swallow count never overshoots A
  assert_swallow_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    a_cnt_q <= a_act);

  // R3: once the long phase ends it does not come back within the cycle
  assert_long_phase_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_long && !cycle_end) |=> !use_long);

endmodule

// File: rtl/dmod_settings.sv
module dmod_settings
  import dmod_pkg::*;
#(
  parameter int PRE_P = 4,
  parameter int M_W   = 4,
  parameter int A_W   = 3,
  parameter int DEF_M = 3,
  parameter int DEF_A = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [M_W-1:0] m_in,
  input  logic [A_W-1:0] a_in,
  input  logic           boundary,
  output logic [M_W-1:0] m_act,
  output logic [A_W-1:0] a_act,
  output logic [M_W-1:0] m_nxt,
  output logic           cfg_err
);

  logic [M_W-1:0] pend_m_q;
  logic [A_W-1:0] pend_a_q;
  logic           pend_v_q;
  logic           req_ok;
  logic           take;

  assign req_ok = setting_legal(int'(m_in), int'(a_in), PRE_P);
  assign take   = boundary && pend_v_q;
  assign m_nxt  = take ? pend_m_q : m_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_act    <= M_W'(DEF_M);
      a_act    <= A_W'(DEF_A);
      pend_m_q <= '0;
      pend_a_q <= '0;
      pend_v_q <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      if (take) begin
        m_act <= pend_m_q;
        a_act <= pend_a_q;
      end
      if (load && req_ok) begin
        pend_m_q <= m_in;
        pend_a_q <= a_in;
        pend_v_q <= 1'b1;
        cfg_err  <= 1'b0;
      end else begin
        if (boundary) pend_v_q <= 1'b0;
        if (load) cfg_err <= 1'b1;
      end
    end
  end

  // R6: the running settings are always legal
  assert_active_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_act != '0) && (int'(a_act) < PRE_P) && (int'(m_act) >= int'(a_act)));

  // R6: a rejected request raises the flag
  assert_err_on_bad_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !req_ok) |=> cfg_err);

  // R7: an accepted request clears the flag
  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && req_ok) |=> !cfg_err);

  // R5: settings move only at a cycle boundary
  assert_hold_between_boundaries_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(m_act) && $stable(a_act)));

endmodule

// File: rtl/dmod_divider.sv
module dmod_divider
  import dmod_pkg::*;
#(
  parameter int PRE_P = 4,
  parameter int M_W   = 4,
  parameter int A_W   = $clog2(PRE_P + 1),
  parameter int DEF_M = 3,
  parameter int DEF_A = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [M_W-1:0] m_in,
  input  logic [A_W-1:0] a_in,
  output logic           div_pulse,
  output logic           div_clk,
  output logic           cfg_err
);

  localparam int PC_W = $clog2(PRE_P + 1);

  logic [M_W-1:0]  m_act;
  logic [A_W-1:0]  a_act;
  logic [M_W-1:0]  m_nxt;
  logic            use_long;
  logic            pre_tick;
  logic [PC_W-1:0] pre_phase;
  logic            cycle_end;
  logic [M_W-1:0]  m_cnt_next;
  logic [M_W:0]    half_w;
  logic            clk_hi_next;

  dmod_settings #(
    .PRE_P(PRE_P), .M_W(M_W), .A_W(A_W), .DEF_M(DEF_M), .DEF_A(DEF_A)
  ) u_settings (
    .clk(clk), .rst_n(rst_n), .load(load), .m_in(m_in), .a_in(a_in),
    .boundary(cycle_end), .m_act(m_act), .a_act(a_act), .m_nxt(m_nxt),
    .cfg_err(cfg_err)
  );

  dmod_prescaler #(.PRE_P(PRE_P)) u_prescaler (
    .clk(clk), .rst_n(rst_n), .use_long(use_long), .tick(pre_tick),
    .phase(pre_phase)
  );

  dmod_counters #(.M_W(M_W), .A_W(A_W)) u_counters (
    .clk(clk), .rst_n(rst_n), .tick(pre_tick), .m_act(m_act), .a_act(a_act),
    .use_long(use_long), .cycle_end(cycle_end), .m_cnt_next(m_cnt_next)
  );

  assign half_w      = (M_W+1)'(high_span(int'(m_nxt)));
  assign clk_hi_next = ({1'b0, m_cnt_next} < half_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_pulse <= 1'b0;
      div_clk   <= 1'b1;
    end else begin
      div_pulse <= cycle_end;
      div_clk   <= clk_hi_next;
    end
  end

  // R4: with no swallow the prescaler never reaches its long count
  assert_short_only_when_a_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_act == '0) |-> (int'(pre_phase) < PRE_P));

  // R8: the boundary pulse lasts a single clock
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R9: the divided clock only rises together with the boundary pulse
  assert_clk_rise_with_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_clk) |-> div_pulse);

  // R9: each cycle starts with the divided clock high
  assert_clk_high_at_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> div_clk);

endmodule

// File: tb/dmod_divider_bench.sv
module dmod_divider_bench;

  localparam int P  = 4;
  localparam int MW = 4;
  localparam int AW = $clog2(P + 1);
  localparam int DM = 3;
  localparam int DA = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [MW-1:0] m_in = '0;
  logic [AW-1:0] a_in = '0;
  logic          div_pulse;
  logic          div_clk;
  logic          cfg_err;

  dmod_divider #(.PRE_P(P), .M_W(MW), .DEF_M(DM), .DEF_A(DA)) u_dmod_divider (
    .clk(clk), .rst_n(rst_n), .load(load), .m_in(m_in), .a_in(a_in),
    .div_pulse(div_pulse), .div_clk(div_clk), .cfg_err(cfg_err)
  );

  always #10 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    ivl = 0;
  int    cur_r, cur_m, pend_r, pend_m;
  bit    pend_v = 0;
  bit    stray = 0;
  logic  prev_clk = 1'b1;
  logic  prev_pulse = 1'b0;
  string tag_now = "R2";

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // expected interval, built by counting long and short prescaler periods
  function automatic int expect_len(int m, int a);
    return a * (P + 1) + (m - a) * P;
  endfunction

  function automatic bit is_legal(int m, int a);
    return !(m == 0 || a >= P || a > m);
  endfunction

  task automatic step();
    @(negedge clk);
    cyc++;
    ivl++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
    if (div_clk && !prev_clk && !div_pulse) stray = 1;
    if (div_pulse) begin
      check(ivl == cur_r, tag_now, ivl, cur_r);
      check(!prev_pulse, "R8 pulse width", int'(prev_pulse), 0);
      if (cur_m >= 2) check(div_clk && !prev_clk, "R9 rise at boundary", int'(div_clk), 1);
      else check(div_clk, "R9 stays high for M=1", int'(div_clk), 1);
      check(!stray, "R9 stray rise", int'(stray), 0);
      stray = 0;
      ivl = 0;
      if (pend_v) begin
        cur_r = pend_r;
        cur_m = pend_m;
        pend_v = 0;
      end
    end
    prev_clk = div_clk;
    prev_pulse = div_pulse;
  endtask

  task automatic wait_pulse(input string tag);
    tag_now = tag;
    do step(); while (!div_pulse);
  endtask

  task automatic drive_load(input int m, input int a);
    m_in = MW'(m);
    a_in = AW'(a);
    load = 1'b1;
    step();
    load = 1'b0;
    if (is_legal(m, a)) begin
      pend_r = expect_len(m, a);
      pend_m = m;
      pend_v = 1;
      check(cfg_err == 1'b0, "R7 err cleared", int'(cfg_err), 0);
    end else begin
      check(cfg_err == 1'b1, "R6 err raised", int'(cfg_err), 1);
    end
  endtask

  initial begin
    cur_r = expect_len(DM, DA);
    cur_m = DM;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(div_pulse == 1'b0, "R10 pulse in reset", int'(div_pulse), 0);
    check(cfg_err == 1'b0, "R10 err in reset", int'(cfg_err), 0);
    check(div_clk == 1'b1, "R10 clk in reset", int'(div_clk), 1);
    rst_n = 1'b1;
    ivl = 0;

    wait_pulse("R2 first cycle");
    wait_pulse("R1 default ratio");

    // R11: every contiguous ratio, decomposed by the bench
    for (int n = P * (P - 1); n <= (2**MW - 1) * P + P - 1; n++) begin
      wait_pulse("R1 interval");
      drive_load(n / P, n % P);
      wait_pulse("R5 old ratio kept");
      wait_pulse("R11 contiguous ratio");
    end

    // small M corners, including A=0 (R4) and A=M
    for (int m = 1; m <= 2; m++) begin
      for (int a = 0; a <= m; a++) begin
        wait_pulse("R1 interval");
        drive_load(m, a);
        wait_pulse("R5 old ratio kept");
        wait_pulse(a == 0 ? "R4 no swallow" : "R1 small M");
      end
    end

    // known base before illegal requests
    wait_pulse("R1 interval");
    drive_load(6, 2);
    wait_pulse("R5 old ratio kept");
    wait_pulse("R1 base ratio");

    // R6: illegal requests leave the ratio unchanged
    wait_pulse("R6 interval"); drive_load(2, 3);
    wait_pulse("R6 M below A"); wait_pulse("R6 M below A");
    wait_pulse("R6 interval"); drive_load(5, 4);
    wait_pulse("R6 A equals P"); wait_pulse("R6 A equals P");
    wait_pulse("R6 interval"); drive_load(0, 0);
    wait_pulse("R6 M zero"); wait_pulse("R6 M zero");
    wait_pulse("R6 interval"); drive_load(9, 7);
    wait_pulse("R6 A above P"); wait_pulse("R6 A above P");
    check(cfg_err == 1'b1, "R6 err sticks", int'(cfg_err), 1);

    // R7 and R12: two legal loads in one cycle, last one wins
    wait_pulse("R12 interval");
    drive_load(5, 2);
    drive_load(9, 3);
    wait_pulse("R12 old ratio kept");
    wait_pulse("R12 last load wins");
    wait_pulse("R12 last load holds");

    finish_run();
  end

endmodule